// File: doc/BRIEF.md
# Sequential Shift and Rotate Engine with Extend Flag

This block carries out the shift and rotate group of a register-based processor: arithmetic shifts, logical shifts, rotates that pass through an extend bit, and plain rotates, each in either direction, on byte, word or long operands. The surrounding execution unit hands it a 16-bit instruction word, the data operand, the value of the register that may hold a shift count, and the current extend flag. The block returns the shifted operand together with new extend, negative, zero, overflow and carry flags.

The engine moves the operand one bit position per clock. A `start` pulse taken while the engine is idle captures every input. `busy` stays high while bits are moving, and `done` pulses for one cycle once the result and flags are final. They then hold until the next accepted start. The single-bit memory form is decoded here as well, but fetching and storing that operand is left to the caller.

Top module: `shift_rotate_engine`

## Requirements
- R1: Register form decoding uses these instruction fields: bit 8 is the direction (0 right, 1 left), bits 7:6 are the size (00 byte, 01 word, 10 long), bit 5 is the count source, bits 4:3 are the kind (00 arithmetic, 01 logical, 10 rotate through extend, 11 plain rotate), and bits 11:9 are the count field. Bits 15:12 and 2:0 are not decoded.
- R2: With bit 5 at 0 the count is bits 11:9, and a field value of 0 means 8. With bit 5 at 1 the count is `cnt_val` modulo 64.
- R3: Size code 11 selects the memory form. It acts on a word with a count of exactly one, and it takes its kind from bits 10:9 (same coding as R1).
- R4: N equals the top bit of the sized result and Z is set when the sized result is zero. For a non-zero count, C is the last bit shifted out.
- R5: An arithmetic left shift sets V when the sign bit changes at any step. An arithmetic right shift fills the top with the sign bit. Every other kind, and the arithmetic right shift, leaves V cleared.
- R6: A logical shift fills with zero, and for a non-zero count X takes the value of C.
- R7: A rotate through extend shifts the X bit in at the vacated end and moves the bit shifted out into X. At the end, X equals C.
- R8: A plain rotate feeds the bit shifted out back in at the other end and leaves X at its input value.
- R9: For a count of zero the sized result is unchanged, C is cleared and X is kept. For a rotate through extend, C takes the value of X instead.
- R10: For the byte and word sizes, result bits above the size keep the operand's value.
- R11: A start pulse while idle is accepted, and `busy` is high on the next cycle. `done` is a one-cycle pulse, count+1 cycles after the accepting edge. A start pulse while busy is ignored, and the result holds while the engine is idle with no start.
- R12: After reset, `busy`, `done`, `result` and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation; taken only while idle |
| instr | input | 16 | Instruction word of the shift or rotate |
| opnd | input | DATA_W | Operand to be shifted |
| cnt_val | input | DATA_W | Value of the register that holds the count |
| x_in | input | 1 | Extend flag before the operation |
| busy | output | 1 | High while bits are being moved |
| done | output | 1 | One-cycle pulse when the result and flags are final |
| result | output | DATA_W | Shifted operand |
| x_out | output | 1 | Extend flag after the operation |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
The bench builds the engine with its default parameters: a 32-bit datapath, a 6-bit count and an immediate zero mapped to 8. Under these values a register count of 63 is reachable, which drives a single bit across the whole long word and out of it, so overflow and carry are exercised past the sign position. The 6-bit count also means a `cnt_val` with high bits set and low six bits zero selects the zero-count path. Both count sources, all three register sizes and the memory form are driven, and latency is measured against count+1 for every vector.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      SH_ARITH = 2'b00,
      SH_LOGIC = 2'b01,
      SH_ROTX  = 2'b10,
      SH_ROT   = 2'b11
   } sh_kind_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10
   } sz_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } eng_state_e;

   // instruction field positions the decoder relies on
   localparam int DIR_BIT      = 8;
   localparam int SIZE_LO      = 6;
   localparam int SRC_BIT      = 5;
   localparam int KIND_LO      = 3;
   localparam int CNT_LO       = 9;
   localparam int MEM_KIND_LO  = 9;

endpackage

// File: rtl/srx_decode.sv
module srx_decode
   import srx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 6,
   parameter int IMM_ZERO = 8
) (
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] cnt_val,
   output sh_kind_e          kind,
   output logic              left,
   output sz_e               size,
   output logic [CNT_W-1:0]  count
);

   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO_MAP = CNT_W'(IMM_ZERO);

   logic [1:0] sz_code;
   logic       mem_form;
   logic [2:0] imm_field;
   logic       unused_bits;

   assign sz_code   = instr[SIZE_LO +: 2];
   assign mem_form  = (sz_code == 2'b11);
   assign imm_field = instr[CNT_LO +: 3];
   assign left      = instr[DIR_BIT];

   assign unused_bits = ^{instr[15:12], instr[2:0], cnt_val[DATA_W-1:CNT_W]};

   always_comb begin
      if (mem_form) begin
         size  = SZ_WORD;
         kind  = sh_kind_e'(instr[MEM_KIND_LO +: 2]);
         count = ONE_CNT;
      end else begin
         size = sz_e'(sz_code);
         kind = sh_kind_e'(instr[KIND_LO +: 2]);
         if (instr[SRC_BIT]) begin
            count = cnt_val[CNT_W-1:0];
         end else if (imm_field == 3'd0) begin
            count = ZERO_MAP;
         end else begin
            count = CNT_W'(imm_field);
         end
      end
   end

endmodule

// File: rtl/srx_step.sv
module srx_step
   import srx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] val,
   input  sh_kind_e          kind,
   input  logic              left,
   input  sz_e               size,
   input  logic              x,
   input  logic              v,
   output logic [DATA_W-1:0] val_nx,
   output logic              out_bit,
   output logic              x_nx,
   output logic              v_nx
);

   localparam int NLANE = 3;

   logic [DATA_W-1:0] lane_val [NLANE];
   logic [NLANE-1:0]  lane_out;
   logic [NLANE-1:0]  lane_sc;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int W = 8 << g;
      logic [W-1:0] f;
      logic [W-1:0] nf;
      logic         fill;
      logic         o;

      assign f = val[W-1:0];

      always_comb begin
         if (left) begin
            case (kind)
               SH_ROTX: fill = x;
               SH_ROT:  fill = f[W-1];
               default: fill = 1'b0;
            endcase
            nf = {f[W-2:0], fill};
            o  = f[W-1];
         end else begin
            case (kind)
               SH_ARITH: fill = f[W-1];
               SH_LOGIC: fill = 1'b0;
               SH_ROTX:  fill = x;
               default:  fill = f[0];
            endcase
            nf = {fill, f[W-1:1]};
            o  = f[0];
         end
      end

      assign lane_out[g] = o;
      assign lane_sc[g]  = nf[W-1] ^ f[W-1];

      if (W == DATA_W) begin : g_full
         assign lane_val[g] = nf;
      end else begin : g_part
         assign lane_val[g] = {val[DATA_W-1:W], nf};
      end
   end

   logic sc;

   always_comb begin
      case (size)
         SZ_BYTE: begin
            val_nx  = lane_val[0];
            out_bit = lane_out[0];
            sc      = lane_sc[0];
         end
         SZ_WORD: begin
            val_nx  = lane_val[1];
            out_bit = lane_out[1];
            sc      = lane_sc[1];
         end
         default: begin
            val_nx  = lane_val[2];
            out_bit = lane_out[2];
            sc      = lane_sc[2];
         end
      endcase
   end

   assign v_nx = v | ((kind == SH_ARITH) & left & sc);
   assign x_nx = (kind == SH_ROT) ? x : out_bit;

endmodule

// File: rtl/srx_nz.sv
module srx_nz
   import srx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] val,
   input  sz_e               size,
   output logic              neg,
   output logic              zero
);

   always_comb begin
      case (size)
         SZ_BYTE: begin
            neg  = val[7];
            zero = (val[7:0] == 8'd0);
         end
         SZ_WORD: begin
            neg  = val[15];
            zero = (val[15:0] == 16'd0);
         end
         default: begin
            neg  = val[DATA_W-1];
            zero = (val == '0);
         end
      endcase
   end

endmodule

// File: rtl/shift_rotate_engine.sv
module shift_rotate_engine
   import srx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 6,
   parameter int IMM_ZERO = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] cnt_val,
   input  logic              x_in,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              x_out,
   output logic              n_out,
   output logic              z_out,
   output logic              v_out,
   output logic              c_out
);

   if (DATA_W != 32) begin : g_bad_width
      $error("shift_rotate_engine: DATA_W must be 32 for byte/word/long sizes");
   end
   if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("shift_rotate_engine: CNT_W out of range");
   end
   if (IMM_ZERO < 1 || IMM_ZERO >= (1 << CNT_W)) begin : g_bad_imm
      $error("shift_rotate_engine: IMM_ZERO does not fit the count");
   end

   sh_kind_e           dec_kind;
   logic               dec_left;
   sz_e                dec_size;
   logic [CNT_W-1:0]   dec_count;

   srx_decode #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .IMM_ZERO (IMM_ZERO)
   ) u_dec (
      .instr   (instr),
      .cnt_val (cnt_val),
      .kind    (dec_kind),
      .left    (dec_left),
      .size    (dec_size),
      .count   (dec_count)
   );

   eng_state_e         state_q;
   logic [DATA_W-1:0]  val_q;
   logic [CNT_W-1:0]   cnt_q;
   sh_kind_e           kind_q;
   logic               left_q;
   sz_e                size_q;
   logic               x_q, v_q, c_q, n_q, z_q;
   logic               done_q;

   logic [DATA_W-1:0]  step_val;
   logic               step_out, step_x, step_v;
   logic               fin_n, fin_z;

   srx_step #(.DATA_W(DATA_W)) u_step (
      .val     (val_q),
      .kind    (kind_q),
      .left    (left_q),
      .size    (size_q),
      .x       (x_q),
      .v       (v_q),
      .val_nx  (step_val),
      .out_bit (step_out),
      .x_nx    (step_x),
      .v_nx    (step_v)
   );

   srx_nz #(.DATA_W(DATA_W)) u_nz (
      .val  (val_q),
      .size (size_q),
      .neg  (fin_n),
      .zero (fin_z)
   );

   logic accept;
   assign accept = start && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         val_q   <= '0;
         cnt_q   <= '0;
         kind_q  <= SH_ARITH;
         left_q  <= 1'b0;
         size_q  <= SZ_BYTE;
         x_q     <= 1'b0;
         v_q     <= 1'b0;
         c_q     <= 1'b0;
         n_q     <= 1'b0;
         z_q     <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state_q <= ST_RUN;
            val_q   <= opnd;
            cnt_q   <= dec_count;
            kind_q  <= dec_kind;
            left_q  <= dec_left;
            size_q  <= dec_size;
            x_q     <= x_in;
            v_q     <= 1'b0;
            c_q     <= (dec_kind == SH_ROTX) ? x_in : 1'b0;
         end else if (state_q == ST_RUN) begin
            if (cnt_q != '0) begin
               val_q <= step_val;
               x_q   <= step_x;
               v_q   <= step_v;
               c_q   <= step_out;
               cnt_q <= cnt_q - 1'b1;
            end else begin
               state_q <= ST_IDLE;
               n_q     <= fin_n;
               z_q     <= fin_z;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign busy   = (state_q == ST_RUN);
   assign done   = done_q;
   assign result = val_q;
   assign x_out  = x_q;
   assign n_out  = n_q;
   assign z_out  = z_q;
   assign v_out  = v_q;
   assign c_out  = c_q;

endmodule

// File: rtl/srx_chk.sv
module srx_chk
   import srx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] opnd,
   input logic              x_in,
   input logic [DATA_W-1:0] result,
   input logic              x_out,
   input logic              n_out,
   input logic              z_out,
   input logic              v_out,
   input sh_kind_e          kind_q,
   input sz_e               size_q
);

   logic [DATA_W-1:0] opnd_seen;
   logic              x_seen;
   logic [DATA_W-1:0] fld;
   logic              fld_msb;

   always_ff @(posedge clk) begin
      if (start && !busy) begin
         opnd_seen <= opnd;
         x_seen    <= x_in;
      end
   end

   always_comb begin
      case (size_q)
         SZ_BYTE: begin
            fld     = DATA_W'(result[7:0]);
            fld_msb = result[7];
         end
         SZ_WORD: begin
            fld     = DATA_W'(result[15:0]);
            fld_msb = result[15];
         end
         default: begin
            fld     = result;
            fld_msb = result[DATA_W-1];
         end
      endcase
   end

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

   p_nz_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (z_out == (fld == '0)) && (n_out == fld_msb));

   p_v_arith_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q != SH_ARITH) |-> !v_out);

   p_rot_keeps_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && kind_q == SH_ROT) |-> (x_out == x_seen));

   p_upper_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && size_q == SZ_BYTE) |-> (result[DATA_W-1:8] == opnd_seen[DATA_W-1:8]));

   p_upper_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && size_q == SZ_WORD) |-> (result[DATA_W-1:16] == opnd_seen[DATA_W-1:16]));

endmodule

bind shift_rotate_engine srx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .opnd   (opnd),
   .x_in   (x_in),
   .result (result),
   .x_out  (x_out),
   .n_out  (n_out),
   .z_out  (z_out),
   .v_out  (v_out),
   .kind_q (kind_q),
   .size_q (size_q)
);

// File: tb/sim_shift_rotate_engine.sv
module sim_shift_rotate_engine;

   localparam int DW = 32;

   typedef struct packed {
      logic [15:0]   ins;
      logic [DW-1:0] op;
      logic [DW-1:0] cv;
      logic          xi;
      logic [DW-1:0] res;
      logic [4:0]    fl;   // {X,N,Z,V,C}
      int            lat;  // count + 1
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{16'hE308, 32'hAABBCC81, 32'h00000000, 1'b0, 32'hAABBCC02, 5'b10001, 2},
      '{16'hE440, 32'h12348003, 32'h00000000, 1'b0, 32'h1234E000, 5'b11001, 3},
      '{16'hE100, 32'h00000040, 32'h00000000, 1'b0, 32'h00000000, 5'b00110, 9},
      '{16'hE6B0, 32'h00000001, 32'hFFFFFFC1, 1'b1, 32'h80000000, 5'b11001, 2},
      '{16'hE758, 32'hFFFFC001, 32'h00000000, 1'b1, 32'hFFFF000E, 5'b10000, 4},
      '{16'hE0A8, 32'h80000000, 32'h00000040, 1'b1, 32'h80000000, 5'b11000, 1},
      '{16'hE130, 32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 5'b10101, 1},
      '{16'hE1D0, 32'h55554000, 32'h00000000, 1'b0, 32'h55558000, 5'b01010, 2},
      '{16'hE4F9, 32'h00000003, 32'h00000000, 1'b0, 32'h00000001, 5'b10001, 2},
      '{16'hE200, 32'h12345681, 32'h00000000, 1'b0, 32'h123456C0, 5'b11001, 2},
      '{16'hE048, 32'hABCD00FF, 32'h00000000, 1'b0, 32'hABCD0000, 5'b10101, 9},
      '{16'hE1A0, 32'h00000001, 32'h0000003F, 1'b0, 32'h00000000, 5'b00110, 64},
      '{16'hE298, 32'h00000001, 32'h00000000, 1'b0, 32'h80000000, 5'b01001, 2},
      '{16'hE550, 32'h00008000, 32'h00000000, 1'b0, 32'h00000001, 5'b00000, 3}
   };
   // requirement tags per row
   localparam string TAGS [NV] = '{
      "R1 R6", "R5", "R2 R5", "R2 R7", "R8", "R9 R2", "R9 R7",
      "R3 R5", "R3 R7", "R5 R10", "R6 R4", "R5 R2", "R8", "R7"
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [15:0]   instr = '0;
   logic [DW-1:0] opnd = '0;
   logic [DW-1:0] cnt_val = '0;
   logic          x_in = 1'b0;
   logic          busy, done;
   logic [DW-1:0] result;
   logic          x_out, n_out, z_out, v_out, c_out;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   shift_rotate_engine #(.DATA_W(DW), .CNT_W(6), .IMM_ZERO(8)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .instr   (instr),
      .opnd    (opnd),
      .cnt_val (cnt_val),
      .x_in    (x_in),
      .busy    (busy),
      .done    (done),
      .result  (result),
      .x_out   (x_out),
      .n_out   (n_out),
      .z_out   (z_out),
      .v_out   (v_out),
      .c_out   (c_out)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      instr   = v.ins;
      opnd    = v.op;
      cnt_val = v.cv;
      x_in    = v.xi;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!done && cyc < 300);
   endtask

   task automatic check_vec(input vec_t v, input string tag, input int cyc);
      logic [4:0] fl;
      fl = {x_out, n_out, z_out, v_out, c_out};
      chk(result == v.res, {tag, " result"}, 64'(result), 64'(v.res));
      chk(fl == v.fl, {tag, " flags XNZVC"}, 64'(fl), 64'(v.fl));
      chk(cyc == v.lat, {tag, " R11 latency"}, 64'(cyc), 64'(v.lat));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      chk(busy == 1'b0 && done == 1'b0, "R12 busy/done", 64'({busy, done}), 64'd0);
      chk(result == '0, "R12 result", 64'(result), 64'd0);
      chk({x_out, n_out, z_out, v_out, c_out} == 5'b0, "R12 flags",
          64'({x_out, n_out, z_out, v_out, c_out}), 64'd0);

      for (int i = 0; i < NV; i++) begin
         int cyc;
         drive(VECS[i]);
         wait_done(cyc);
         check_vec(VECS[i], TAGS[i], cyc);
         @(negedge clk);
      end

      // R11: start while busy is ignored
      begin
         int cyc;
         vec_t other;
         other = VECS[0];
         drive(VECS[11]);
         repeat (10) @(negedge clk);
         instr   = other.ins;
         opnd    = 32'h5A5A5A5A;
         cnt_val = other.cv;
         x_in    = 1'b1;
         start   = 1'b1;
         @(negedge clk);
         start   = 1'b0;
         cyc = 11;
         while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
         end
         check_vec(VECS[11], "R11 busy-start", cyc);
         @(negedge clk);
         chk(done == 1'b0, "R11 done pulse", 64'(done), 64'd0);
         repeat (3) @(negedge clk);
         chk(result == VECS[11].res && busy == 1'b0, "R11 hold idle",
             64'(result), 64'(VECS[11].res));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule